// File: doc/BRIEF.md
# Display Controller Register Interface

This block is the control and status register front end of an indexed-colour display controller. It sits on a 21-bit register window and serves byte, halfword and word accesses through a single-cycle request handshake. It holds the control word, the frame-store start offset, the displayed width and height, and the pointer position. It drives those values to the video pipeline, which lies outside this block.

Three lookup arrays live outside the block and are reached through one shared array port: the colour lookup table, the three-entry pointer colour table and the pointer bitmap. A narrow write is turned into a full-word update by merging the new lane into the word currently held at that location. A narrow read selects its lane from that word. The block also decodes pixel depth from the control word. It keeps a refresh interrupt that each frame tick raises and each write lowers, and it offers a software reset location.

Top module: `vidctl_csr`

## Requirements
- R1: After `rst_n` is released, `ctrl_word`, `top_offset`, `cursor_xy`, `disp_width`, `disp_height`, `irq`, `rvalid` and `arr_clear` are all zero, and `depth_bpp` is 1.
- R2: A read request (`req`=1, `we`=0) gives `rvalid`=1, with the result on `rdata`, exactly one cycle later. In every other cycle `rvalid` is 0.
- R3: A word read of address 0x000000 returns 0x10. Writes to that address change nothing.
- R4: A write of value v to 0x080118 sets `disp_width` to v*4, truncated to DIM_W bits. A word read there returns `disp_width`/4.
- R5: A write of value v to 0x080150 sets `disp_height` to v/2, rounded down. A word read there returns `disp_height`*2.
- R6: A write to 0x080300 sets `ctrl_word`, and a word read there returns it. `depth_bpp` follows `ctrl_word[22:20]` as 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, and 6 or 7→0.
- R7: A write to 0x080400 sets `top_offset`, and a write to 0x080638 sets `cursor_xy`. Reads of both addresses return 0.
- R8: The array port uses word address wa = addr with bits 1:0 cleared. `arr_sel` is 0 for the colour table (0x080800 ≤ wa < 0x081000), 1 for the pointer colours (0x080508 ≤ wa < 0x080520) and 2 for the pointer bitmap (0x081000 ≤ wa < 0x082000), and 3 otherwise. `arr_idx` = (wa − base)/8, and `arr_we` pulses with a write in that same cycle. A read of the pointer bitmap returns `arr_rdata[15:0]` zero-extended. A read of the pointer colours returns `arr_rdata[23:0]` zero-extended. A read of the colour table returns 0.
- R9: `size` 0 is a byte, 1 is a halfword and 2 is a word. A byte write replaces lane addr[1:0] (bits 8*lane+7 down to 8*lane) of the current word. A halfword write replaces bits 31:16 when addr[1]=1 and bits 15:0 otherwise. The merged word is stored in the register or driven on `arr_wdata`.
- R10: A byte read returns (word >> 8*addr[1:0]) & 0xFF. A halfword read returns word[31:16] when addr[1]=1 and word[15:0] otherwise. A word read ignores addr[1:0].
- R11: Writes to any other address, timing registers included (for example 0x080000, 0x080108, 0x080148, 0x080200), change no output except `irq`. Reads of such addresses return 0.
- R12: `frame_tick` sets `irq` one cycle later. Any write clears `irq` one cycle later and wins over a `frame_tick` in the same cycle.
- R13: A write to 0x180000 clears every register and `irq` one cycle later, and raises `arr_clear` for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word |
| addr | input | 21 | Byte address in the register window |
| wdata | input | 32 | Write data, right-aligned for narrow writes |
| rdata | output | 32 | Read data, right-aligned |
| rvalid | output | 1 | Read data valid, one cycle after a read |
| frame_tick | input | 1 | Frame refresh pulse |
| irq | output | 1 | Refresh interrupt |
| ctrl_word | output | 32 | Control word |
| depth_bpp | output | 5 | Decoded bits per pixel |
| top_offset | output | 32 | Frame-store start offset |
| cursor_xy | output | 32 | Pointer position |
| disp_width | output | DIM_W | Width in pixels |
| disp_height | output | DIM_W | Height in lines |
| arr_sel | output | 2 | Array select (R8) |
| arr_idx | output | 9 | Array entry index |
| arr_we | output | 1 | Array write strobe |
| arr_wdata | output | 32 | Merged array write word |
| arr_rdata | input | 32 | Array read word, combinational on sel/idx |
| arr_clear | output | 1 | Pulse that asks the arrays to clear |

## Verification
Register writes, `irq` and `arr_clear` change on the clock edge that accepts the request. Read data and `rvalid` appear on that same edge, so every result is due one cycle after the request. The bench drives each request on a falling edge and removes it on the next falling edge, and it samples at that point. Every check therefore reads the values produced by exactly one rising edge. The bench models the arrays itself, writing them on the rising edge when `arr_we` is high, so a narrow array write can be followed by a read-back on the very next request.

// File: rtl/vidctl_csr.sv
module vidctl_csr #(
  parameter int DIM_W = 16,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic [1:0]       size,
  input  logic [20:0]      addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             rvalid,
  input  logic             frame_tick,
  output logic             irq,
  output logic [31:0]      ctrl_word,
  output logic [4:0]       depth_bpp,
  output logic [31:0]      top_offset,
  output logic [31:0]      cursor_xy,
  output logic [DIM_W-1:0] disp_width,
  output logic [DIM_W-1:0] disp_height,
  output logic [1:0]       arr_sel,
  output logic [IDX_W-1:0] arr_idx,
  output logic             arr_we,
  output logic [31:0]      arr_wdata,
  input  logic [31:0]      arr_rdata,
  output logic             arr_clear
);
  localparam logic [20:0] A_ID  = 21'h000000;
  localparam logic [20:0] A_WID = 21'h080118;
  localparam logic [20:0] A_HGT = 21'h080150;
  localparam logic [20:0] A_CTL = 21'h080300;
  localparam logic [20:0] A_TOP = 21'h080400;
  localparam logic [20:0] A_CPL = 21'h080508;
  localparam logic [20:0] A_CPS = 21'h080638;
  localparam logic [20:0] A_PAL = 21'h080800;
  localparam logic [20:0] A_PAT = 21'h081000;
  localparam logic [20:0] A_RST = 21'h180000;

  logic [20:0] wa, off;
  logic [31:0] cur, merged, lane_rd;
  logic        hit_pal, hit_cpl, hit_pat, wr, rd;
  logic [4:0]  sh;

  assign wa      = {addr[20:2], 2'b00};
  assign sh      = {addr[1:0], 3'b000};
  assign wr      = req && we;
  assign rd      = req && !we;
  assign hit_pal = (wa >= A_PAL) && (wa < A_PAL + 21'h000800);
  assign hit_cpl = (wa >= A_CPL) && (wa < A_CPL + 21'h000018);
  assign hit_pat = (wa >= A_PAT) && (wa < A_PAT + 21'h001000);

  always_comb begin
    arr_sel = 2'd3;
    off     = '0;
    if (hit_pal) begin
      arr_sel = 2'd0;
      off     = wa - A_PAL;
    end else if (hit_cpl) begin
      arr_sel = 2'd1;
      off     = wa - A_CPL;
    end else if (hit_pat) begin
      arr_sel = 2'd2;
      off     = wa - A_PAT;
    end
  end
  assign arr_idx = off[IDX_W+2:3];

  always_comb begin
    if (hit_pat)      cur = {16'h0, arr_rdata[15:0]};
    else if (hit_cpl) cur = {8'h0, arr_rdata[23:0]};
    else begin
      case (wa)
        A_ID:    cur = 32'h10;
        A_WID:   cur = 32'(disp_width >> 2);
        A_HGT:   cur = 32'(disp_height) << 1;
        A_CTL:   cur = ctrl_word;
        default: cur = '0;
      endcase
    end
  end

  always_comb begin
    case (size)
      2'd0:    merged = (cur & ~(32'hFF << sh)) | ({24'h0, wdata[7:0]} << sh);
      2'd1:    merged = addr[1] ? {wdata[15:0], cur[15:0]} : {cur[31:16], wdata[15:0]};
      default: merged = wdata;
    endcase
    case (size)
      2'd0:    lane_rd = (cur >> sh) & 32'hFF;
      2'd1:    lane_rd = addr[1] ? {16'h0, cur[31:16]} : {16'h0, cur[15:0]};
      default: lane_rd = cur;
    endcase
  end

  assign arr_we    = wr && (hit_pal || hit_cpl || hit_pat);
  assign arr_wdata = merged;

  always_comb begin
    case (ctrl_word[22:20])
      3'd0:    depth_bpp = 5'd1;
      3'd1:    depth_bpp = 5'd2;
      3'd2:    depth_bpp = 5'd4;
      3'd3:    depth_bpp = 5'd8;
      3'd4:    depth_bpp = 5'd15;
      3'd5:    depth_bpp = 5'd16;
      default: depth_bpp = 5'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid      <= 1'b0;
      rdata       <= '0;
      irq         <= 1'b0;
      arr_clear   <= 1'b0;
      ctrl_word   <= '0;
      top_offset  <= '0;
      cursor_xy   <= '0;
      disp_width  <= '0;
      disp_height <= '0;
    end else begin
      rvalid    <= rd;
      arr_clear <= wr && (wa == A_RST);
      if (rd) rdata <= lane_rd;
      if (wr) irq <= 1'b0;
      else if (frame_tick) irq <= 1'b1;
      if (wr) begin
        case (wa)
          A_WID: disp_width  <= DIM_W'(merged << 2);
          A_HGT: disp_height <= DIM_W'(merged >> 1);
          A_CTL: ctrl_word   <= merged;
          A_TOP: top_offset  <= merged;
          A_CPS: cursor_xy   <= merged;
          A_RST: begin
            ctrl_word   <= '0;
            top_offset  <= '0;
            cursor_xy   <= '0;
            disp_width  <= '0;
            disp_height <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |=> rvalid); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !we) |=> !rvalid); // R2
  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && size == 2'd2 && addr[20:2] == 19'h0) |=> (rdata == 32'h10)); // R3
  AST_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> !irq); // R12
  AST_TICK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !(req && we)) |=> irq); // R12
  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && addr[20:2] == A_RST[20:2]) |=>
      (arr_clear && ctrl_word == 32'h0 && disp_width == '0 && disp_height == '0)); // R13
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_clear |=> !arr_clear || $past(req && we)); // R13
endmodule

// File: tb/test_vidctl_csr.sv
module test_vidctl_csr;
  localparam int DIM_W = 16;
  logic clk = 0, rst_n = 0, req = 0, we = 0, frame_tick = 0;
  logic [1:0]  size = 0;
  logic [20:0] addr = 0;
  logic [31:0] wdata = 0, rdata, ctrl_word, top_offset, cursor_xy, arr_wdata, arr_rdata;
  logic [4:0]  depth_bpp;
  logic [DIM_W-1:0] disp_width, disp_height;
  logic [1:0]  arr_sel;
  logic [8:0]  arr_idx;
  logic        rvalid, irq, arr_we, arr_clear;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  vidctl_csr #(.DIM_W(DIM_W), .IDX_W(9)) i_vidctl_csr (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .frame_tick(frame_tick),
    .irq(irq), .ctrl_word(ctrl_word), .depth_bpp(depth_bpp), .top_offset(top_offset),
    .cursor_xy(cursor_xy), .disp_width(disp_width), .disp_height(disp_height),
    .arr_sel(arr_sel), .arr_idx(arr_idx), .arr_we(arr_we), .arr_wdata(arr_wdata),
    .arr_rdata(arr_rdata), .arr_clear(arr_clear));

  logic [23:0] m_pal [256];
  logic [23:0] m_cpl [4];
  logic [15:0] m_pat [512];

  always_comb begin
    case (arr_sel)
      2'd0:    arr_rdata = {8'h0, m_pal[arr_idx[7:0]]};
      2'd1:    arr_rdata = {8'h0, m_cpl[arr_idx[1:0]]};
      2'd2:    arr_rdata = {16'h0, m_pat[arr_idx]};
      default: arr_rdata = '0;
    endcase
  end

  always @(posedge clk) begin
    if (arr_clear) begin
      for (int i = 0; i < 256; i++) m_pal[i] <= '0;
      for (int i = 0; i < 4; i++)   m_cpl[i] <= '0;
      for (int i = 0; i < 512; i++) m_pat[i] <= '0;
    end else if (arr_we) begin
      case (arr_sel)
        2'd0: m_pal[arr_idx[7:0]] <= arr_wdata[23:0];
        2'd1: m_cpl[arr_idx[1:0]] <= arr_wdata[23:0];
        2'd2: m_pat[arr_idx]      <= arr_wdata[15:0];
        default: ;
      endcase
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] sz, input logic [20:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; size = sz; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input string r, input logic [1:0] sz, input logic [20:0] a, input logic [31:0] exp);
    acc(0, sz, a, 0);
    chk("R2 rvalid", {31'h0, rvalid}, 32'h1);
    chk(r, rdata, exp);
  endtask

  function automatic logic [4:0] bpp(input int k);
    case (k)
      0: return 5'd1; 1: return 5'd2; 2: return 5'd4;
      3: return 5'd8; 4: return 5'd15; 5: return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] w, e;
    for (int i = 0; i < 256; i++) m_pal[i] = '0;
    for (int i = 0; i < 4; i++)   m_cpl[i] = '0;
    for (int i = 0; i < 512; i++) m_pat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", ctrl_word, 0);
    chk("R1 top", top_offset, 0);
    chk("R1 cursor", cursor_xy, 0);
    chk("R1 width", 32'(disp_width), 0);
    chk("R1 height", 32'(disp_height), 0);
    chk("R1 irq/rvalid/clear", {29'h0, irq, rvalid, arr_clear}, 0);
    chk("R1 depth", 32'(depth_bpp), 1);

    // R3 identity, R10 lanes
    rd("R3 id", 2'd2, 21'h000000, 32'h10);
    acc(1, 2'd2, 21'h000000, 32'hFFFF_FFFF);
    chk("R2 no rvalid on write", {31'h0, rvalid}, 0);
    rd("R3 id after write", 2'd2, 21'h000000, 32'h10);
    rd("R10 id byte0", 2'd0, 21'h000000, 32'h10);
    rd("R10 id byte1", 2'd0, 21'h000001, 32'h0);

    // R4 width sweep
    for (int v = 0; v < 80; v++) begin
      w = (v < 64) ? 32'(v) : 32'(v * 613 + 16'h3FF0);
      acc(1, 2'd2, 21'h080118, w);
      e = (w * 4) & 32'hFFFF;
      chk("R4 width", 32'(disp_width), e);
      rd("R4 width read", 2'd2, 21'h080118, e >> 2);
    end

    // R5 height sweep
    for (int v = 0; v < 80; v++) begin
      w = (v < 64) ? 32'(v) : 32'(v * 977 + 32'h1_0000);
      acc(1, 2'd2, 21'h080150, w);
      e = (w >> 1) & 32'hFFFF;
      chk("R5 height", 32'(disp_height), e);
      rd("R5 height read", 2'd2, 21'h080150, e << 1);
    end

    // R6 control and depth table
    for (int k = 0; k < 8; k++) begin
      w = (32'(k) << 20) | 32'h0000_0400 | 32'(k);
      acc(1, 2'd2, 21'h080300, w);
      chk("R6 ctrl", ctrl_word, w);
      chk("R6 depth", 32'(depth_bpp), 32'(bpp(k)));
      rd("R6 ctrl read", 2'd2, 21'h080300, w);
    end

    // R7 write-only registers
    acc(1, 2'd2, 21'h080400, 32'hDEAD_0100);
    acc(1, 2'd2, 21'h080638, 32'h0012_3045);
    chk("R7 top", top_offset, 32'hDEAD_0100);
    chk("R7 cursor", cursor_xy, 32'h0012_3045);
    rd("R7 top read", 2'd2, 21'h080400, 0);
    rd("R7 cursor read", 2'd2, 21'h080638, 0);

    // R9 narrow writes and R10 narrow reads on control
    for (int l = 0; l < 4; l++) begin
      acc(1, 2'd2, 21'h080300, 32'h1122_3344);
      acc(1, 2'd0, 21'h080300 + 21'(l), 32'hFFFF_FFAB);
      e = (32'h1122_3344 & ~(32'hFF << (8 * l))) | (32'hAB << (8 * l));
      chk("R9 byte merge", ctrl_word, e);
      rd("R10 byte read", 2'd0, 21'h080300 + 21'(l), (e >> (8 * l)) & 32'hFF);
      rd("R10 word ignores low bits", 2'd2, 21'h080300 + 21'(l), e);
    end
    for (int h = 0; h < 2; h++) begin
      acc(1, 2'd2, 21'h080300, 32'h1122_3344);
      acc(1, 2'd1, 21'h080300 + 21'(2 * h), 32'hAAAA_BEEF);
      e = h ? 32'hBEEF_3344 : 32'h1122_BEEF;
      chk("R9 half merge", ctrl_word, e);
      rd("R10 half read", 2'd1, 21'h080300 + 21'(2 * h), h ? e >> 16 : e & 32'hFFFF);
    end
    acc(1, 2'd1, 21'h080118, 32'h0000_0005);
    chk("R9 half into width", 32'(disp_width), 32'h14);

    // R8 array routing
    for (int i = 0; i < 256; i++) begin
      w = 32'(i) * 32'h0001_0307 ^ 32'hFF00_00A5;
      acc(1, 2'd2, 21'h080800 + 21'(8 * i), w);
      chk("R8 colour entry", 32'(m_pal[i]), w & 32'hFF_FFFF);
    end
    rd("R8 colour read zero", 2'd2, 21'h080808, 0);
    acc(1, 2'd0, 21'h080809, 32'h77);
    chk("R9 colour byte merge into zero", 32'(m_pal[1]), 32'h7700);
    for (int i = 0; i < 3; i++) begin
      w = 32'h5500_0000 | (32'(i + 1) * 32'h0010_2030);
      acc(1, 2'd2, 21'h080508 + 21'(8 * i), w);
      rd("R8 pointer colour read", 2'd2, 21'h080508 + 21'(8 * i), w & 32'hFF_FFFF);
    end
    acc(1, 2'd0, 21'h080512, 32'hC3);
    rd("R9 pointer colour byte merge", 2'd2, 21'h080510, 32'hC3_4060);
    rd("R8 past pointer colours", 2'd2, 21'h080520, 0);
    for (int i = 0; i < 512; i++) begin
      w = 32'hABCD_0000 | 32'(i * 37 + 1);
      acc(1, 2'd2, 21'h081000 + 21'(8 * i), w);
      rd("R8 bitmap read", 2'd2, 21'h081000 + 21'(8 * i), w & 32'hFFFF);
    end

    // R11 ignored addresses
    acc(1, 2'd2, 21'h080300, 32'h0030_0000);
    foreach (e[i]) ;
    acc(1, 2'd2, 21'h080000, 32'hFFFF_FFFF);
    acc(1, 2'd2, 21'h080108, 32'hFFFF_FFFF);
    acc(1, 2'd2, 21'h080148, 32'hFFFF_FFFF);
    acc(1, 2'd2, 21'h080200, 32'hFFFF_FFFF);
    chk("R11 ctrl kept", ctrl_word, 32'h0030_0000);
    chk("R11 width kept", 32'(disp_width), 32'h14);
    chk("R11 top kept", top_offset, 32'hDEAD_0100);
    chk("R11 cursor kept", cursor_xy, 32'h0012_3045);
    rd("R11 unmapped read", 2'd2, 21'h080108, 0);
    rd("R11 unmapped read high", 2'd2, 21'h1F0000, 0);

    // R12 interrupt
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    chk("R12 tick raises", {31'h0, irq}, 1);
    acc(1, 2'd2, 21'h080148, 0);
    chk("R12 write lowers", {31'h0, irq}, 0);
    @(negedge clk); frame_tick = 1; req = 1; we = 1; size = 2; addr = 21'h080200;
    @(negedge clk); frame_tick = 0; req = 0; we = 0;
    chk("R12 write wins", {31'h0, irq}, 0);
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;

    // R13 soft reset
    acc(1, 2'd2, 21'h180000, 32'h1);
    chk("R13 clear pulse", {31'h0, arr_clear}, 1);
    chk("R13 irq", {31'h0, irq}, 0);
    chk("R13 ctrl", ctrl_word, 0);
    chk("R13 top/cursor", top_offset | cursor_xy, 0);
    chk("R13 dims", 32'(disp_width) | 32'(disp_height), 0);
    @(negedge clk);
    chk("R13 clear one cycle", {31'h0, arr_clear}, 0);
    rd("R13 bitmap cleared", 2'd2, 21'h081008, 0);
    chk("R13 colour cleared", 32'(m_pal[7]), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule